// File: doc/BRIEF.md
# Interrupt source state controller

This block keeps the state of a small array of interrupt sources and turns source events into presentation requests for a downstream presenter. Each source is fixed at build time as level-sensitive, message-style (edge) or unused. Each source holds a target server number, a priority and a four-flag status: asserted, sent, rejected and masked-pending. A priority of all ones masks the source.

Source lines, configuration writes, rejects, end-of-interrupt notices and resend requests update the status flags. A source that qualifies for presentation is marked queued. Queued sources leave through a single valid/ready output one per accepted handshake, lowest index first. The output carries the server, the global number and the priority. Global numbers are the local index plus a build-time base, and incoming reject and end-of-interrupt numbers are mapped back by subtracting that base.

Top module: `sic_top`

## Requirements
- R1: Reset leaves no presentation pending, gives every source priority all-ones (masked), server 0 and cleared flags, and keeps each source's kind (which comes from the LSI_MAP and MSI_MAP build parameters).
- R2: A presentation shows `pr_num` = BASE + local index, together with the server and priority most recently written to that source.
- R3: A rising edge on a message source's line sets its masked-pending flag without presenting when its priority is all-ones, and queues it for presentation otherwise.
- R4: A configuration write that leaves a masked-pending message source unmasked clears the flag and presents the source once; a repeated write presents nothing.
- R5: A level source's asserted flag follows its line. The source is presented only when it is unmasked, asserted and not sent, and presenting sets sent, so a new rising edge while sent presents nothing.
- R6: A reject of number N acts on local index N - BASE: it sets rejected on a message source and clears sent on a level source. Numbers outside [BASE, BASE+NSRC) are ignored.
- R7: A resend clears rejected on every rejected message source and re-presents it only when unmasked. Every level source re-applies the rule of R5.
- R8: An end-of-interrupt clears sent on a level source and does not present by itself. On a message source it has no effect.
- R9: A configuration write to a level source re-applies the rule of R5 with the new priority.
- R10: Sources of unused kind never present, whatever their line, configuration, reject, end-of-interrupt or resend stimulus.
- R11: Queued sources present one per accepted handshake in ascending index order, and while `pr_valid` is high with `pr_ready` low the presented number does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_line | input | NSRC | Per-source interrupt lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local source index of the write |
| cfg_server | input | SRV_W | Server number to store |
| cfg_prio | input | PRIO_W | Priority to store (all ones masks) |
| rej_valid | input | 1 | Reject strobe from the presenter |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number being completed |
| resend | input | 1 | Resend request strobe |
| pr_valid | output | 1 | Presentation valid |
| pr_ready | input | 1 | Presenter accepts the presentation |
| pr_server | output | SRV_W | Target server of the presented source |
| pr_num | output | NUM_W | Global number of the presented source |
| pr_prio | output | PRIO_W | Priority of the presented source |

## Verification
The hardest state to reach is a message source that was rejected and then masked before the resend. It must come out with rejected cleared and masked-pending still clear, so a later unmask presents nothing. The stimulus rejects the source, masks it, issues a resend, then unmasks it, and observes silence on the output. A second difficult case is a lower-index source that becomes queued while a higher-index presentation is stalled. The bench holds `pr_ready` low across that arrival and checks that the held number stays in place before the drain order is checked.

// File: rtl/sic_pkg.sv
package sic_pkg;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_LSI  = 2'd1,
        KIND_MSI  = 2'd2
    } src_kind_e;

    // per-source status flags
    typedef struct packed {
        logic asserted;
        logic sent;
        logic rejected;
        logic mpend;
    } src_flags_t;

    // events reaching one source in one cycle
    typedef struct packed {
        logic cfg_wr;
        logic rej;
        logic eoi;
        logic line_chg;
        logic line_lvl;
        logic rise;
        logic resend;
        logic taken;
    } src_evt_t;

    localparam src_flags_t FLAGS_CLEAR = '{default: 1'b0};

    function automatic src_kind_e kind_of(input logic is_lsi, input logic is_msi);
        if (is_lsi)      return KIND_LSI;
        else if (is_msi) return KIND_MSI;
        else             return KIND_NONE;
    endfunction

endpackage

// File: rtl/sic_numdec.sv
module sic_numdec #(
    parameter int NSRC = 16,
    parameter int NUM_W = 16,
    parameter logic [NUM_W-1:0] BASE = '0
) (
    input  logic             vld,
    input  logic [NUM_W-1:0] num,
    output logic [NSRC-1:0]  hit
);
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [NUM_W-1:0] off;

    always_comb begin
        off = num - BASE;
        hit = '0;
        if (vld && (num >= BASE) && (off < NUM_W'(NSRC)))
            hit[off[IDX_W-1:0]] = 1'b1;
    end
endmodule

// File: rtl/sic_pick.sv
module sic_pick #(
    parameter int N = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req,
    input  logic             stall,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    logic [IDX_W-1:0] low_idx;
    logic             hold_q;
    logic [IDX_W-1:0] hold_idx_q;

    // lowest requesting index
    always_comb begin
        low_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) low_idx = IDX_W'(i);
        end
    end

    assign any = |req;
    assign idx = hold_q ? hold_idx_q : low_idx;

    always_comb begin
        gnt = '0;
        if (any) gnt[idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q     <= 1'b0;
            hold_idx_q <= '0;
        end else begin
            hold_q     <= any && stall;
            hold_idx_q <= idx;
        end
    end
endmodule

// File: rtl/sic_slot.sv
module sic_slot
    import sic_pkg::*;
#(
    parameter src_kind_e KIND = KIND_MSI,
    parameter int SRV_W = 8,
    parameter int PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  src_evt_t          evt,
    input  logic [SRV_W-1:0]  cfg_server,
    input  logic [PRIO_W-1:0] cfg_prio,
    output logic              queued,
    output logic [SRV_W-1:0]  cur_server,
    output logic [PRIO_W-1:0] cur_prio
);
    localparam logic [PRIO_W-1:0] PRIO_OFF = '1;

    generate
        if (KIND == KIND_NONE) begin : g_unused
            assign queued     = 1'b0;
            assign cur_server = '0;
            assign cur_prio   = PRIO_OFF;
        end else begin : g_live
            src_flags_t        flg_q, flg_n;
            logic              q_q, q_n;
            logic [SRV_W-1:0]  srv_q, srv_n;
            logic [PRIO_W-1:0] pri_q, pri_n;

            always_comb begin
                flg_n = flg_q;
                q_n   = q_q && !evt.taken;
                srv_n = srv_q;
                pri_n = pri_q;
                if (evt.cfg_wr) begin
                    srv_n = cfg_server;
                    pri_n = cfg_prio;
                end
                if (KIND == KIND_LSI) begin
                    if (evt.rej || evt.eoi) flg_n.sent = 1'b0;
                    if (evt.line_chg) flg_n.asserted = evt.line_lvl;
                    if ((evt.cfg_wr || evt.line_chg || evt.resend) &&
                        (pri_n != PRIO_OFF) && flg_n.asserted && !flg_n.sent) begin
                        flg_n.sent = 1'b1;
                        q_n        = 1'b1;
                    end
                end else begin
                    if (evt.cfg_wr && flg_n.mpend && (pri_n != PRIO_OFF)) begin
                        flg_n.mpend = 1'b0;
                        q_n         = 1'b1;
                    end
                    if (evt.rej) flg_n.rejected = 1'b1;
                    if (evt.rise) begin
                        if (pri_n == PRIO_OFF) flg_n.mpend = 1'b1;
                        else                   q_n = 1'b1;
                    end
                    if (evt.resend && flg_n.rejected) begin
                        flg_n.rejected = 1'b0;
                        if (pri_n != PRIO_OFF) q_n = 1'b1;
                    end
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    flg_q <= FLAGS_CLEAR;
                    q_q   <= 1'b0;
                    srv_q <= '0;
                    pri_q <= PRIO_OFF;
                end else begin
                    flg_q <= flg_n;
                    q_q   <= q_n;
                    srv_q <= srv_n;
                    pri_q <= pri_n;
                end
            end

            assign queued     = q_q;
            assign cur_server = srv_q;
            assign cur_prio   = pri_q;
        end
    endgenerate
endmodule

// File: rtl/sic_top.sv
module sic_top
    import sic_pkg::*;
#(
    parameter int NSRC = 16,
    parameter int SRV_W = 8,
    parameter int PRIO_W = 8,
    parameter int NUM_W = 16,
    parameter logic [NUM_W-1:0] BASE = 16'h1000,
    parameter logic [NSRC-1:0] LSI_MAP = 16'h003F,
    parameter logic [NSRC-1:0] MSI_MAP = 16'h3FC0,
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_line,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [SRV_W-1:0]  cfg_server,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic              rej_valid,
    input  logic [NUM_W-1:0]  rej_num,
    input  logic              eoi_valid,
    input  logic [NUM_W-1:0]  eoi_num,
    input  logic              resend,
    output logic              pr_valid,
    input  logic              pr_ready,
    output logic [SRV_W-1:0]  pr_server,
    output logic [NUM_W-1:0]  pr_num,
    output logic [PRIO_W-1:0] pr_prio
);
    logic [NSRC-1:0]   line_q;
    logic [NSRC-1:0]   line_chg, line_rise;
    logic [NSRC-1:0]   rej_hit, eoi_hit, cfg_hit;
    logic [NSRC-1:0]   queued, gnt, taken;
    logic [IDX_W-1:0]  sel_idx;
    logic              sel_any;
    logic [SRV_W-1:0]  srv_arr  [NSRC];
    logic [PRIO_W-1:0] prio_arr [NSRC];

    always_ff @(posedge clk) begin
        if (rst) line_q <= '0;
        else     line_q <= src_line;
    end

    assign line_chg  = src_line ^ line_q;
    assign line_rise = src_line & ~line_q;

    sic_numdec #(.NSRC(NSRC), .NUM_W(NUM_W), .BASE(BASE)) i_rej_dec (
        .vld(rej_valid), .num(rej_num), .hit(rej_hit)
    );

    sic_numdec #(.NSRC(NSRC), .NUM_W(NUM_W), .BASE(BASE)) i_eoi_dec (
        .vld(eoi_valid), .num(eoi_num), .hit(eoi_hit)
    );

    always_comb begin
        for (int i = 0; i < NSRC; i++)
            cfg_hit[i] = cfg_we && (cfg_idx == IDX_W'(i));
    end

    assign taken = gnt & {NSRC{pr_valid && pr_ready}};

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_src
            src_evt_t evt;
            assign evt.cfg_wr   = cfg_hit[g];
            assign evt.rej      = rej_hit[g];
            assign evt.eoi      = eoi_hit[g];
            assign evt.line_chg = line_chg[g];
            assign evt.line_lvl = src_line[g];
            assign evt.rise     = line_rise[g];
            assign evt.resend   = resend;
            assign evt.taken    = taken[g];

            sic_slot #(
                .KIND(kind_of(LSI_MAP[g], MSI_MAP[g])),
                .SRV_W(SRV_W),
                .PRIO_W(PRIO_W)
            ) i_slot (
                .clk(clk),
                .rst(rst),
                .evt(evt),
                .cfg_server(cfg_server),
                .cfg_prio(cfg_prio),
                .queued(queued[g]),
                .cur_server(srv_arr[g]),
                .cur_prio(prio_arr[g])
            );
        end
    endgenerate

    sic_pick #(.N(NSRC)) i_pick (
        .clk(clk),
        .rst(rst),
        .req(queued),
        .stall(pr_valid && !pr_ready),
        .gnt(gnt),
        .idx(sel_idx),
        .any(sel_any)
    );

    assign pr_valid  = sel_any;
    assign pr_num    = BASE + NUM_W'(sel_idx);
    assign pr_server = srv_arr[sel_idx];
    assign pr_prio   = prio_arr[sel_idx];
endmodule

// File: rtl/sic_chk.sv
module sic_chk #(
    parameter int NSRC = 16,
    parameter int NUM_W = 16,
    parameter logic [NUM_W-1:0] BASE = '0,
    parameter logic [NSRC-1:0] TYPED = '1
) (
    input logic             clk,
    input logic             rst,
    input logic             pr_valid,
    input logic             pr_ready,
    input logic [NUM_W-1:0] pr_num,
    input logic [NSRC-1:0]  gnt
);
    // R1: nothing is presented in the cycle after reset
    p_idle_after_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> !pr_valid);

    // R2: presented numbers lie inside the source window
    p_num_window_r2: assert property (@(posedge clk) disable iff (rst)
        pr_valid |-> ((pr_num >= BASE) && ((pr_num - BASE) < NUM_W'(NSRC))));

    // R10: only typed sources are ever granted
    p_typed_only_r10: assert property (@(posedge clk) disable iff (rst)
        pr_valid |-> |(gnt & TYPED));

    // R11: exactly one grant while valid, none otherwise
    p_single_grant_r11: assert property (@(posedge clk) disable iff (rst)
        $countones(gnt) == (pr_valid ? 1 : 0));

    // R11: a stalled presentation keeps its number
    p_stall_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (pr_valid && !pr_ready) |=> (pr_valid && $stable(pr_num)));
endmodule

bind sic_top sic_chk #(
    .NSRC(NSRC),
    .NUM_W(NUM_W),
    .BASE(BASE),
    .TYPED(LSI_MAP | MSI_MAP)
) i_chk (
    .clk(clk),
    .rst(rst),
    .pr_valid(pr_valid),
    .pr_ready(pr_ready),
    .pr_num(pr_num),
    .gnt(gnt)
);

// File: tb/test_sic_top.sv
`timescale 1ns/1ps
module test_sic_top;
    localparam int NSRC = 16;
    localparam int NUM_W = 16;
    localparam int BASE = 16'h1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] src_line = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [7:0]  cfg_server = '0;
    logic [7:0]  cfg_prio = '0;
    logic        rej_valid = 1'b0;
    logic [15:0] rej_num = '0;
    logic        eoi_valid = 1'b0;
    logic [15:0] eoi_num = '0;
    logic        resend = 1'b0;
    logic        pr_valid;
    logic        pr_ready = 1'b1;
    logic [7:0]  pr_server;
    logic [15:0] pr_num;
    logic [7:0]  pr_prio;

    int tot = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    sic_top i_sic_top (
        .clk(clk), .rst(rst), .src_line(src_line),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_server(cfg_server), .cfg_prio(cfg_prio),
        .rej_valid(rej_valid), .rej_num(rej_num),
        .eoi_valid(eoi_valid), .eoi_num(eoi_num),
        .resend(resend),
        .pr_valid(pr_valid), .pr_ready(pr_ready),
        .pr_server(pr_server), .pr_num(pr_num), .pr_prio(pr_prio)
    );

    function automatic int srv_of(input int i);
        return (i * 37 + 5) % 256;
    endfunction

    function automatic int pri_of(input int i);
        return (i * 11 + 1) % 200;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tot++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // every driving task starts and ends at a falling edge
    task automatic cfg(input int i, input int s, input int p);
        cfg_we = 1'b1; cfg_idx = 4'(i); cfg_server = 8'(s); cfg_prio = 8'(p);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input int i);
        src_line[i] = 1'b1;
        @(negedge clk);
        src_line[i] = 1'b0;
    endtask

    task automatic level(input int i, input bit v);
        src_line[i] = v;
        @(negedge clk);
    endtask

    task automatic rej(input int n);
        rej_valid = 1'b1; rej_num = 16'(n);
        @(negedge clk);
        rej_valid = 1'b0;
    endtask

    task automatic eoi(input int n);
        eoi_valid = 1'b1; eoi_num = 16'(n);
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic rsnd();
        resend = 1'b1;
        @(negedge clk);
        resend = 1'b0;
    endtask

    task automatic expect_pres(input int i, input int p, input string req);
        chk(pr_valid === 1'b1, req, "valid", pr_valid, 1);
        chk(pr_num === 16'(BASE + i), req, "num", pr_num, BASE + i);
        chk(pr_server === 8'(srv_of(i)), req, "server", pr_server, srv_of(i));
        chk(pr_prio === 8'(p), req, "prio", pr_prio, p);
        @(negedge clk);
    endtask

    task automatic expect_none(input string req, input int n);
        for (int k = 0; k < n; k++) begin
            chk(pr_valid === 1'b0, req, "idle", pr_valid, 0);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", tot, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        expect_none("R1", 2);

        // R1 R3 R4: masked message sources go pending, unmask presents once
        for (int i = 6; i <= 13; i++) begin
            pulse(i);
            expect_none("R3", 1);
            cfg(i, srv_of(i), pri_of(i));
            expect_pres(i, pri_of(i), "R4");
            expect_none("R4", 1);
            cfg(i, srv_of(i), pri_of(i));
            expect_none("R4", 1);
        end

        // R2 R3: unmasked message sources present at once
        for (int i = 6; i <= 13; i++) begin
            pulse(i);
            expect_pres(i, pri_of(i), "R3");
            expect_none("R2", 1);
        end

        // level sources
        for (int i = 0; i <= 5; i++) begin
            level(i, 1'b1);
            expect_none("R1", 1);
            cfg(i, srv_of(i), pri_of(i));
            expect_pres(i, pri_of(i), "R9");
            level(i, 1'b0);
            level(i, 1'b1);
            expect_none("R5", 1);
            eoi(BASE + i);
            expect_none("R8", 1);
            level(i, 1'b0);
            level(i, 1'b1);
            expect_pres(i, pri_of(i), "R5");
            rej(BASE + i);
            expect_none("R6", 1);
            rsnd();
            expect_pres(i, pri_of(i), "R7");
            rsnd();
            expect_none("R7", 1);
            level(i, 1'b0);
            eoi(BASE + i);
            rsnd();
            expect_none("R5", 1);
        end

        // message reject / eoi / resend
        for (int i = 6; i <= 13; i++) begin
            eoi(BASE + i);
            rsnd();
            expect_none("R8", 1);
            rej(BASE + i);
            eoi(BASE + i);
            expect_none("R6", 1);
            rsnd();
            expect_pres(i, pri_of(i), "R8");
            rsnd();
            expect_none("R7", 1);
        end

        // rejected then masked before the resend
        rej(BASE + 7);
        cfg(7, srv_of(7), 8'hFF);
        rsnd();
        expect_none("R7", 1);
        cfg(7, srv_of(7), pri_of(7));
        expect_none("R7", 1);
        rsnd();
        expect_none("R7", 1);

        // out-of-window numbers
        rej(BASE - 1);
        rej(BASE + NSRC);
        rsnd();
        expect_none("R6", 2);

        // unused sources
        for (int i = 14; i <= 15; i++) begin
            pulse(i);
            cfg(i, srv_of(i), pri_of(i));
            level(i, 1'b1);
            rej(BASE + i);
            eoi(BASE + i);
            rsnd();
            level(i, 1'b0);
            expect_none("R10", 2);
        end

        // drain order and stall hold
        pr_ready = 1'b0;
        src_line[6] = 1'b1; src_line[9] = 1'b1; src_line[12] = 1'b1;
        @(negedge clk);
        src_line = '0;
        for (int k = 0; k < 3; k++) begin
            chk(pr_valid === 1'b1 && pr_num === 16'(BASE + 6), "R11", "stall num", pr_num, BASE + 6);
            @(negedge clk);
        end
        pr_ready = 1'b1;
        expect_pres(6, pri_of(6), "R11");
        expect_pres(9, pri_of(9), "R11");
        expect_pres(12, pri_of(12), "R11");
        expect_none("R11", 1);

        // lower index arrives while a higher one is held
        pr_ready = 1'b0;
        pulse(12);
        chk(pr_num === 16'(BASE + 12), "R11", "held num", pr_num, BASE + 12);
        pulse(8);
        chk(pr_num === 16'(BASE + 12), "R11", "held num", pr_num, BASE + 12);
        pr_ready = 1'b1;
        expect_pres(12, pri_of(12), "R11");
        expect_pres(8, pri_of(8), "R11");
        expect_none("R11", 1);

        // level and message together
        pr_ready = 1'b0;
        src_line[2] = 1'b1; src_line[10] = 1'b1;
        @(negedge clk);
        src_line[10] = 1'b0;
        pr_ready = 1'b1;
        expect_pres(2, pri_of(2), "R11");
        expect_pres(10, pri_of(10), "R11");
        level(2, 1'b0);
        eoi(BASE + 2);
        expect_none("R11", 1);

        // reset with a pending presentation
        pr_ready = 1'b0;
        pulse(6);
        chk(pr_valid === 1'b1, "R1", "pre-reset valid", pr_valid, 1);
        pr_ready = 1'b1;
        do_reset();
        expect_none("R1", 1);
        pulse(6);
        expect_none("R1", 1);
        cfg(6, srv_of(6), pri_of(6));
        expect_pres(6, pri_of(6), "R1");
        expect_none("R1", 1);

        $display("test done: total=%0d bad=%0d", tot, bad);
        $finish;
    end
endmodule